// File: doc/BRIEF.md
# Branch-Driven Bound Register Init

This block keeps a bank of bound registers, four by default. Each entry is 128 bits wide and holds a lower bound and a stored upper bound. The upper bound is kept one's-complemented, so an entry of all zeros is the init state and covers the whole address space. The block watches the retire stream for near branches. When a branch retires and was taken or executed, it carries no bound prefix, the preserve control is clear and the enable for the current privilege level is set, every bound entry returns to the init state. Branches that qualify are relative and indirect calls, returns with and without an immediate, relative and indirect jumps, and one- and two-byte conditional jumps. Indirect forms are recognised through the reg field of the ModRM byte.

The block also holds a bound status register. A bound-range fault reported by a bounds-check instruction clears this register, but only when the OS extended-state flag, both bound-state enable flags and the privilege-selected enable are all set. In every other case the fault leaves the register alone. Plain write ports let the surrounding pipeline load bound entries and the status register. Full instruction decode and fault delivery are left to the surrounding logic.

Top module: `bndinit_unit`

## Requirements
- R1: While rst_n is low, every bound field and the status register read as zero.
- R2: A retired branch with first opcode byte 0xE8, 0xE9, 0xC2, 0xC3, any value 0x70 to 0x7F, or first byte 0x0F with second byte 0x80 to 0x8F sets all bound fields (bnd_lo_o and bnd_hi_o) to zero one clock later, provided R4 to R7 allow it.
- R3: A first byte of 0xFF triggers init only when ModRM bits 5:3 equal 2 or 4. Other ModRM reg values, 0x0F followed by a byte outside 0x80 to 0x8F, and all other opcodes (0xEB for example) never trigger init.
- R4: When bnd_pfx_i is 1, a branch leaves the bound registers unchanged.
- R5: When preserve_i is 1, no branch form changes the bound registers.
- R6: Init takes place only in a cycle where both rv_i and taken_i are 1.
- R7: The active enable is en_user_i when cpl_i equals 3 and en_sup_i otherwise. Both init and the status clear require the active enable to be 1.
- R8: With wr_en_i high, entry wr_idx_i takes wr_lo_i and wr_hi_i at the next edge. Entry i sits at bits [i*ADDR_W +: ADDR_W] of bnd_lo_o and bnd_hi_o, and all other entries keep their values.
- R9: In a cycle where init fires, the bound write port is ignored and all entries become zero.
- R10: bound_fault_i together with os_xstate_i, xs_bndregs_i, xs_bndcsr_i and the active enable clears status_o one clock later.
- R11: In every other case bound_fault_i leaves status_o unmodified. st_wr_en_i loads st_wr_data_i, and with neither input active status_o holds.
- R12: When a status clear and a status write land in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rv_i | input | 1 | Retire-valid strobe for the instruction on the opcode inputs |
| taken_i | input | 1 | The retiring branch was taken or executed |
| bound_fault_i | input | 1 | A bounds-check instruction raised a bound-range fault |
| op0_i | input | 8 | First opcode byte |
| op1_i | input | 8 | Second opcode byte (used after 0x0F) |
| modrm_i | input | 8 | ModRM byte |
| bnd_pfx_i | input | 1 | The instruction carries the 0xF2 bound prefix |
| cpl_i | input | 2 | Current privilege level |
| en_user_i | input | 1 | Bound enable for privilege level 3 |
| en_sup_i | input | 1 | Bound enable for privilege levels 0 to 2 |
| preserve_i | input | 1 | Keep bound registers across branches |
| os_xstate_i | input | 1 | OS extended-state support flag |
| xs_bndregs_i | input | 1 | Bound-register state enable |
| xs_bndcsr_i | input | 1 | Bound-config state enable |
| wr_en_i | input | 1 | Bound entry write strobe |
| wr_idx_i | input | IDX_W | Bound entry index |
| wr_lo_i | input | ADDR_W | Lower bound to write |
| wr_hi_i | input | ADDR_W | Stored upper bound to write |
| st_wr_en_i | input | 1 | Status write strobe |
| st_wr_data_i | input | STAT_W | Status write data |
| bnd_lo_o | output | NUM_BND*ADDR_W | Lower bounds, entry i at bits [i*ADDR_W +: ADDR_W] |
| bnd_hi_o | output | NUM_BND*ADDR_W | Stored upper bounds, same layout |
| status_o | output | STAT_W | Bound status register |

## Verification
Each result is due exactly one rising edge after its stimulus. A branch init, an entry write, a status clear and a status write all show on the outputs after that single edge, and with no input active the state holds. The bench drives inputs on the falling edge and waits for one rising edge. It compares every output on the following falling edge with a bench model that it updates from the same inputs. Because of this, a result that comes a cycle early, a cycle late or in the wrong cycle shows up as a miscompare.

// File: rtl/bndinit_pkg.sv
package bndinit_pkg;

    typedef enum logic [2:0] {
        BK_NONE = 3'd0,
        BK_CALL = 3'd1,
        BK_RET  = 3'd2,
        BK_JMP  = 3'd3,
        BK_JCC  = 3'd4
    } br_kind_e;

    localparam logic [7:0] OPC_CALL_REL = 8'hE8;
    localparam logic [7:0] OPC_JMP_REL  = 8'hE9;
    localparam logic [7:0] OPC_RET_IMM  = 8'hC2;
    localparam logic [7:0] OPC_RET_NEAR = 8'hC3;
    localparam logic [7:0] OPC_GRP_FF   = 8'hFF;
    localparam logic [7:0] OPC_ESCAPE   = 8'h0F;
    localparam logic [3:0] JCC_SHORT_HI = 4'h7;
    localparam logic [3:0] JCC_NEAR_HI  = 4'h8;
    localparam logic [2:0] FF_SUB_CALL  = 3'd2;
    localparam logic [2:0] FF_SUB_JMP   = 3'd4;
    localparam logic [1:0] CPL_USER     = 2'd3;

endpackage

// File: rtl/bndinit_classify.sv
module bndinit_classify
    import bndinit_pkg::*;
(
    input  logic [7:0] op_first_i,
    input  logic [7:0] op_second_i,
    input  logic [2:0] reg_fld_i,
    output br_kind_e   kind_o
);

    always_comb begin
        kind_o = BK_NONE;
        case (op_first_i)
            OPC_CALL_REL: kind_o = BK_CALL;
            OPC_JMP_REL:  kind_o = BK_JMP;
            OPC_RET_IMM,
            OPC_RET_NEAR: kind_o = BK_RET;
            OPC_GRP_FF: begin
                if (reg_fld_i == FF_SUB_CALL) begin
                    kind_o = BK_CALL;
                end else if (reg_fld_i == FF_SUB_JMP) begin
                    kind_o = BK_JMP;
                end
            end
            OPC_ESCAPE: begin
                if (op_second_i[7:4] == JCC_NEAR_HI) begin
                    kind_o = BK_JCC;
                end
            end
            default: begin
                if (op_first_i[7:4] == JCC_SHORT_HI) begin
                    kind_o = BK_JCC;
                end
            end
        endcase
    end

endmodule

// File: rtl/bndinit_policy.sv
module bndinit_policy
    import bndinit_pkg::*;
#(
    parameter int CPL_W = 2
) (
    input  logic             rv_i,
    input  logic             taken_i,
    input  br_kind_e         kind_i,
    input  logic             bnd_pfx_i,
    input  logic             preserve_i,
    input  logic [CPL_W-1:0] cpl_i,
    input  logic             en_user_i,
    input  logic             en_sup_i,
    input  logic             os_xstate_i,
    input  logic             xs_bndregs_i,
    input  logic             xs_bndcsr_i,
    input  logic             bound_fault_i,
    output logic             init_fire_o,
    output logic             stat_clear_o
);

    logic active_en;
    logic legacy_branch;
    logic feature_on;

    always_comb begin
        active_en     = (cpl_i == CPL_W'(CPL_USER)) ? en_user_i : en_sup_i;
        legacy_branch = (kind_i != BK_NONE) && !bnd_pfx_i;
        feature_on    = os_xstate_i && xs_bndregs_i && xs_bndcsr_i;
        init_fire_o   = rv_i && taken_i && legacy_branch && !preserve_i && active_en;
        stat_clear_o  = bound_fault_i && feature_on && active_en;
    end

endmodule

// File: rtl/bndinit_bank.sv
module bndinit_bank #(
    parameter int NUM_BND = 4,
    parameter int ADDR_W  = 64,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BND*ADDR_W-1:0] lo_q_i,
    input  logic [NUM_BND*ADDR_W-1:0] hi_q_i,
    input  logic                      init_i,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [ADDR_W-1:0]         wr_lo_i,
    input  logic [ADDR_W-1:0]         wr_hi_i,
    output logic [NUM_BND*ADDR_W-1:0] lo_d_o,
    output logic [NUM_BND*ADDR_W-1:0] hi_d_o
);

    for (genvar g = 0; g < NUM_BND; g++) begin : g_slot
        logic hit;
        assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));
        assign lo_d_o[g*ADDR_W +: ADDR_W] = init_i ? '0 :
                                           (hit ? wr_lo_i : lo_q_i[g*ADDR_W +: ADDR_W]);
        assign hi_d_o[g*ADDR_W +: ADDR_W] = init_i ? '0 :
                                           (hit ? wr_hi_i : hi_q_i[g*ADDR_W +: ADDR_W]);
    end

endmodule

// File: rtl/bndinit_unit.sv
module bndinit_unit
    import bndinit_pkg::*;
#(
    parameter int NUM_BND = 4,
    parameter int ADDR_W  = 64,
    parameter int STAT_W  = 64,
    parameter int IDX_W   = (NUM_BND > 1) ? $clog2(NUM_BND) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rv_i,
    input  logic                      taken_i,
    input  logic                      bound_fault_i,
    input  logic [7:0]                op0_i,
    input  logic [7:0]                op1_i,
    input  logic [7:0]                modrm_i,
    input  logic                      bnd_pfx_i,
    input  logic [1:0]                cpl_i,
    input  logic                      en_user_i,
    input  logic                      en_sup_i,
    input  logic                      preserve_i,
    input  logic                      os_xstate_i,
    input  logic                      xs_bndregs_i,
    input  logic                      xs_bndcsr_i,
    input  logic                      wr_en_i,
    input  logic [IDX_W-1:0]          wr_idx_i,
    input  logic [ADDR_W-1:0]         wr_lo_i,
    input  logic [ADDR_W-1:0]         wr_hi_i,
    input  logic                      st_wr_en_i,
    input  logic [STAT_W-1:0]         st_wr_data_i,
    output logic [NUM_BND*ADDR_W-1:0] bnd_lo_o,
    output logic [NUM_BND*ADDR_W-1:0] bnd_hi_o,
    output logic [STAT_W-1:0]         status_o
);

    localparam int BANK_W = NUM_BND * ADDR_W;

    typedef struct packed {
        logic [BANK_W-1:0] lo;
        logic [BANK_W-1:0] hi;
        logic [STAT_W-1:0] st;
    } state_t;

    state_t   state_d, state_q;
    br_kind_e kind;
    logic     init_fire;
    logic     stat_clear;
    logic [BANK_W-1:0] bank_lo_d, bank_hi_d;
    logic [4:0] unused_modrm;

    assign unused_modrm = {modrm_i[7:6], modrm_i[2:0]};

    bndinit_classify u_classify (
        .op_first_i  (op0_i),
        .op_second_i (op1_i),
        .reg_fld_i   (modrm_i[5:3]),
        .kind_o      (kind)
    );

    bndinit_policy #(.CPL_W(2)) u_policy (
        .rv_i          (rv_i),
        .taken_i       (taken_i),
        .kind_i        (kind),
        .bnd_pfx_i     (bnd_pfx_i),
        .preserve_i    (preserve_i),
        .cpl_i         (cpl_i),
        .en_user_i     (en_user_i),
        .en_sup_i      (en_sup_i),
        .os_xstate_i   (os_xstate_i),
        .xs_bndregs_i  (xs_bndregs_i),
        .xs_bndcsr_i   (xs_bndcsr_i),
        .bound_fault_i (bound_fault_i),
        .init_fire_o   (init_fire),
        .stat_clear_o  (stat_clear)
    );

    bndinit_bank #(
        .NUM_BND (NUM_BND),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_bank (
        .lo_q_i   (state_q.lo),
        .hi_q_i   (state_q.hi),
        .init_i   (init_fire),
        .wr_en_i  (wr_en_i),
        .wr_idx_i (wr_idx_i),
        .wr_lo_i  (wr_lo_i),
        .wr_hi_i  (wr_hi_i),
        .lo_d_o   (bank_lo_d),
        .hi_d_o   (bank_hi_d)
    );

    always_comb begin
        state_d    = state_q;
        state_d.lo = bank_lo_d;
        state_d.hi = bank_hi_d;
        if (stat_clear) begin
            state_d.st = '0;
        end else if (st_wr_en_i) begin
            state_d.st = st_wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bnd_lo_o = state_q.lo;
    assign bnd_hi_o = state_q.hi;
    assign status_o = state_q.st;

endmodule

// File: rtl/bndinit_chk.sv
module bndinit_chk #(
    parameter int NUM_BND = 4,
    parameter int ADDR_W  = 64,
    parameter int STAT_W  = 64,
    parameter int IDX_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      rv_i,
    input logic                      taken_i,
    input logic                      bound_fault_i,
    input logic [7:0]                op0_i,
    input logic [7:0]                modrm_i,
    input logic                      bnd_pfx_i,
    input logic [1:0]                cpl_i,
    input logic                      en_user_i,
    input logic                      en_sup_i,
    input logic                      preserve_i,
    input logic                      os_xstate_i,
    input logic                      xs_bndregs_i,
    input logic                      xs_bndcsr_i,
    input logic                      wr_en_i,
    input logic [IDX_W-1:0]          wr_idx_i,
    input logic [ADDR_W-1:0]         wr_lo_i,
    input logic                      st_wr_en_i,
    input logic [NUM_BND*ADDR_W-1:0] bnd_lo_o,
    input logic [NUM_BND*ADDR_W-1:0] bnd_hi_o,
    input logic [STAT_W-1:0]         status_o
);

    logic all_feat;
    assign all_feat = os_xstate_i && xs_bndregs_i && xs_bndcsr_i;

    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (bnd_lo_o == '0 && bnd_hi_o == '0 && status_o == '0));

    p_call_init_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rv_i && taken_i && op0_i == 8'hE8 && !bnd_pfx_i && !preserve_i &&
         cpl_i == 2'd3 && en_user_i)
        |=> (bnd_lo_o == '0 && bnd_hi_o == '0));

    p_ff_other_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op0_i == 8'hFF && modrm_i[5:3] != 3'd2 && modrm_i[5:3] != 3'd4 && !wr_en_i)
        |=> ($stable(bnd_lo_o) && $stable(bnd_hi_o)));

    p_prefix_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_pfx_i && !wr_en_i) |=> ($stable(bnd_lo_o) && $stable(bnd_hi_o)));

    p_preserve_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (preserve_i && !wr_en_i) |=> ($stable(bnd_lo_o) && $stable(bnd_hi_o)));

    p_strobe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rv_i || !taken_i) && !wr_en_i) |=> ($stable(bnd_lo_o) && $stable(bnd_hi_o)));

    p_user_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_fault_i && cpl_i == 2'd3 && !en_user_i && !st_wr_en_i)
        |=> $stable(status_o));

    p_entry_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !rv_i)
        |=> (bnd_lo_o[$past(wr_idx_i)*ADDR_W +: ADDR_W] == $past(wr_lo_i)));

    p_write_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rv_i && taken_i && op0_i == 8'hE9 && !bnd_pfx_i && !preserve_i &&
         cpl_i != 2'd3 && en_sup_i && wr_en_i)
        |=> (bnd_lo_o == '0 && bnd_hi_o == '0));

    p_stat_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_fault_i && all_feat && cpl_i == 2'd3 && en_user_i) |=> (status_o == '0));

    p_stat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bound_fault_i && !st_wr_en_i) |=> $stable(status_o));

    p_clear_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bound_fault_i && all_feat && cpl_i != 2'd3 && en_sup_i && st_wr_en_i)
        |=> (status_o == '0));

endmodule

bind bndinit_unit bndinit_chk #(
    .NUM_BND (NUM_BND),
    .ADDR_W  (ADDR_W),
    .STAT_W  (STAT_W),
    .IDX_W   (IDX_W)
) u_chk (.*);

// File: tb/bndinit_unit_test.sv
module bndinit_unit_test;

    localparam int NB = 4;
    localparam int AW = 64;
    localparam int SW = 64;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rv_i, taken_i, bound_fault_i;
    logic [7:0]    op0_i, op1_i, modrm_i;
    logic          bnd_pfx_i;
    logic [1:0]    cpl_i;
    logic          en_user_i, en_sup_i, preserve_i;
    logic          os_xstate_i, xs_bndregs_i, xs_bndcsr_i;
    logic          wr_en_i;
    logic [IW-1:0] wr_idx_i;
    logic [AW-1:0] wr_lo_i, wr_hi_i;
    logic          st_wr_en_i;
    logic [SW-1:0] st_wr_data_i;
    logic [NB*AW-1:0] bnd_lo_o, bnd_hi_o;
    logic [SW-1:0]    status_o;

    logic [NB*AW-1:0] m_lo, m_hi;
    logic [SW-1:0]    m_st;
    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    bndinit_unit #(.NUM_BND(NB), .ADDR_W(AW), .STAT_W(SW)) uut (.*);

    function automatic bit is_branch(logic [7:0] a, logic [7:0] b, logic [7:0] m);
        if (a == 8'hE8 || a == 8'hE9 || a == 8'hC2 || a == 8'hC3) return 1'b1;
        if (a == 8'hFF) return (m[5:3] == 3'd2 || m[5:3] == 3'd4);
        if (a[7:4] == 4'h7) return 1'b1;
        if (a == 8'h0F) return (b[7:4] == 4'h8);
        return 1'b0;
    endfunction

    function automatic bit act_en();
        return (cpl_i == 2'd3) ? en_user_i : en_sup_i;
    endfunction

    function automatic bit exp_init();
        return rv_i && taken_i && is_branch(op0_i, op1_i, modrm_i) &&
               !bnd_pfx_i && !preserve_i && act_en();
    endfunction

    function automatic bit exp_clear();
        return bound_fault_i && os_xstate_i && xs_bndregs_i && xs_bndcsr_i && act_en();
    endfunction

    task automatic model_step();
        if (exp_init()) begin
            m_lo = '0;
            m_hi = '0;
        end else if (wr_en_i) begin
            m_lo[int'(wr_idx_i)*AW +: AW] = wr_lo_i;
            m_hi[int'(wr_idx_i)*AW +: AW] = wr_hi_i;
        end
        if (exp_clear()) m_st = '0;
        else if (st_wr_en_i) m_st = st_wr_data_i;
    endtask

    task automatic compare(string tag);
        vectors++;
        if (bnd_lo_o !== m_lo || bnd_hi_o !== m_hi || status_o !== m_st) begin
            errors++;
            $display("FAIL %s: got lo=%h hi=%h st=%h exp lo=%h hi=%h st=%h",
                     tag, bnd_lo_o, bnd_hi_o, status_o, m_lo, m_hi, m_st);
        end
    endtask

    task automatic apply(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle();
        rv_i = 0; taken_i = 0; bound_fault_i = 0;
        op0_i = 8'h90; op1_i = 8'h00; modrm_i = 8'h00;
        bnd_pfx_i = 0; cpl_i = 2'd3; en_user_i = 1; en_sup_i = 1; preserve_i = 0;
        os_xstate_i = 1; xs_bndregs_i = 1; xs_bndcsr_i = 1;
        wr_en_i = 0; wr_idx_i = '0; wr_lo_i = '0; wr_hi_i = '0;
        st_wr_en_i = 0; st_wr_data_i = '0;
    endtask

    task automatic fill();
        for (int i = 0; i < NB; i++) begin
            idle();
            wr_en_i = 1; wr_idx_i = IW'(i);
            wr_lo_i = {$urandom, $urandom}; wr_hi_i = {$urandom, $urandom};
            apply("R8 entry write");
        end
        idle();
    endtask

    task automatic branch(logic [7:0] a, logic [7:0] b, logic [7:0] m, string tag);
        fill();
        rv_i = 1; taken_i = 1; op0_i = a; op1_i = b; modrm_i = m;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0B1D);
        idle();
        rst_n = 0;
        m_lo = '0; m_hi = '0; m_st = '0;
        wr_en_i = 1; wr_lo_i = '1; st_wr_en_i = 1; st_wr_data_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset state");
        idle();
        rst_n = 1;
        @(negedge clk);

        branch(8'hE8, 8'h00, 8'h00, "R2"); apply("R2 call rel");
        branch(8'hC3, 8'h00, 8'h00, "R2"); apply("R2 ret near");
        branch(8'hC2, 8'h00, 8'h00, "R2"); apply("R2 ret imm");
        branch(8'h7A, 8'h00, 8'h00, "R2"); apply("R2 jcc short");
        branch(8'h0F, 8'h85, 8'h00, "R2"); apply("R2 jcc near");
        branch(8'hFF, 8'h00, 8'h10, "R3"); apply("R3 ff reg2");
        branch(8'hFF, 8'h00, 8'hE0, "R3"); apply("R3 ff reg4");
        branch(8'hFF, 8'h00, 8'h18, "R3"); apply("R3 ff reg3 no init");
        branch(8'hEB, 8'h00, 8'h00, "R3"); apply("R3 short jmp no init");
        branch(8'h0F, 8'h90, 8'h00, "R3"); apply("R3 0f90 no init");
        branch(8'hE9, 8'h00, 8'h00, "R4"); bnd_pfx_i = 1; apply("R4 prefix hold");
        branch(8'hE8, 8'h00, 8'h00, "R5"); preserve_i = 1; apply("R5 preserve hold");
        branch(8'hE8, 8'h00, 8'h00, "R6"); taken_i = 0; apply("R6 not taken");
        branch(8'hE8, 8'h00, 8'h00, "R6"); rv_i = 0; apply("R6 no retire");
        branch(8'hE8, 8'h00, 8'h00, "R7"); cpl_i = 0; en_sup_i = 0; apply("R7 sup disabled");
        branch(8'hE8, 8'h00, 8'h00, "R7"); cpl_i = 1; en_user_i = 0; apply("R7 sup enabled");
        branch(8'hE8, 8'h00, 8'h00, "R7"); en_user_i = 0; apply("R7 user disabled");
        branch(8'hE9, 8'h00, 8'h00, "R9"); cpl_i = 2; wr_en_i = 1; wr_idx_i = 2'd1;
        wr_lo_i = 64'h1234; wr_hi_i = 64'h5678; apply("R9 write dropped on init");

        idle(); st_wr_en_i = 1; st_wr_data_i = 64'hDEAD_BEEF_0000_0042; apply("R11 status write");
        idle(); apply("R11 status hold");
        idle(); bound_fault_i = 1; apply("R10 status clear");
        idle(); st_wr_en_i = 1; st_wr_data_i = 64'h77; apply("R11 status write");
        idle(); bound_fault_i = 1; os_xstate_i = 0; apply("R11 os flag off");
        idle(); bound_fault_i = 1; xs_bndcsr_i = 0; apply("R11 csr state off");
        idle(); bound_fault_i = 1; cpl_i = 1; en_sup_i = 0; apply("R7 fault sup disabled");
        idle(); bound_fault_i = 1; cpl_i = 3; en_user_i = 0; apply("R7 fault user disabled");
        idle(); bound_fault_i = 1; cpl_i = 0; st_wr_en_i = 1; st_wr_data_i = 64'hAB;
        apply("R12 clear beats write");

        for (int n = 0; n < 3000; n++) begin
            string tag;
            idle();
            case ($urandom_range(0, 9))
                0: op0_i = 8'hE8;
                1: op0_i = 8'hE9;
                2: op0_i = 8'hC2;
                3: op0_i = 8'hC3;
                4: op0_i = 8'hFF;
                5: op0_i = {4'h7, 4'($urandom)};
                6: op0_i = 8'h0F;
                7: op0_i = 8'hEB;
                default: op0_i = 8'($urandom);
            endcase
            op1_i = 8'($urandom_range(8'h78, 8'h97));
            modrm_i = 8'($urandom);
            rv_i = ($urandom_range(0, 9) < 8);
            taken_i = ($urandom_range(0, 9) < 7);
            bnd_pfx_i = ($urandom_range(0, 3) == 0);
            preserve_i = ($urandom_range(0, 4) == 0);
            cpl_i = 2'($urandom);
            en_user_i = ($urandom_range(0, 3) != 0);
            en_sup_i = ($urandom_range(0, 3) != 0);
            os_xstate_i = ($urandom_range(0, 6) != 0);
            xs_bndregs_i = ($urandom_range(0, 6) != 0);
            xs_bndcsr_i = ($urandom_range(0, 6) != 0);
            bound_fault_i = ($urandom_range(0, 4) == 0);
            wr_en_i = $urandom_range(0, 1) == 1;
            wr_idx_i = IW'($urandom);
            wr_lo_i = {$urandom, $urandom}; wr_hi_i = {$urandom, $urandom};
            st_wr_en_i = ($urandom_range(0, 2) == 0);
            st_wr_data_i = {$urandom, $urandom};
            if (exp_init()) tag = (op0_i == 8'hFF) ? "R3 random ff" : "R2 random init";
            else if (exp_clear() && st_wr_en_i) tag = "R12 random";
            else if (exp_clear()) tag = "R10 random";
            else if (rv_i && taken_i && bnd_pfx_i) tag = "R4 random";
            else if (preserve_i) tag = "R5 random";
            else if (wr_en_i) tag = "R8 random";
            else tag = "R11 random";
            apply(tag);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule